// File: doc/BRIEF.md
# Vertical Scaling Parameter Generator

This block turns a source height and a destination height into the set of step values that a vertical scaler for a two-plane (luma and chroma) video overlay needs. It first picks a scaling range: enlarge, reduce down to half, or reduce from half to quarter. In the two reduce ranges it pre-divides the source height by 2 or 4. From the pre-divided height it computes one master step value, `(pre_src << 21) / dst`. It then derives the luma and chroma step words from that value with fixed shifts and a fixed offset. It also produces a control word that carries the output-size divider code for both planes.

A computation starts with a one-cycle `start_i` pulse. It runs on a restoring divider that produces one quotient bit per cycle. All results are registered together and announced by a single-cycle `valid_o` strobe. A destination height of zero is rejected with an error flag, and the outputs keep their previous values.

Top module: `vscale_param_gen`

## Requirements
- R1: The range is chosen as follows. Enlarge applies when dst >= src. Half reduction applies when 2*dst >= src. Quarter reduction applies otherwise. The divider code is 2'b00 for enlarge, 2'b01 for half and 2'b10 for quarter. The code is placed in bits [1:0] (luma) and again in bits [9:8] (chroma) of `div_ctrl_o`. All other bits of `div_ctrl_o` are zero.
- R2: In enlarge range, `master_o` = (src * 2^21) / dst, truncated toward zero, keeping the low 32 bits.
- R3: In half range, `master_o` = ((src >> 1) * 2^21) / dst, truncated.
- R4: In quarter range, `master_o` = ((src >> 2) * 2^21) / dst, truncated.
- R5: The luma outputs are: `y_step_a_o` = master >> 2, `y_step_b_o` = `y_step_a_o` + 0x514, and `y_step_c_o` = master.
- R6: The chroma outputs depend on the range. `c_step_a_o` = master >> 2 when enlarging and master >> 3 when reducing. `c_step_b_o` = `c_step_a_o` + 0x514. `c_step_c_o` = master >> 1 when enlarging and master when reducing. `c_step_d_o` = `c_step_c_o`.
- R7: `valid_o` is a one-cycle pulse, raised H_W+22 clock edges after the edge that accepts a start. All outputs change only in the cycle in which `valid_o` is high.
- R8: `busy_o` rises at the accepting edge. It stays high until the edge that raises `valid_o`, and it is low while `valid_o` is high.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The running result uses only the heights captured at acceptance.
- R10: A start with dst = 0 sets `err_o`. It does not raise `busy_o` or `valid_o`, and it leaves all outputs unchanged. `err_o` clears at the next accepted start.
- R11: After reset, all outputs are zero and `busy_o`, `valid_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| src_h_i | input | H_W | Source height |
| dst_h_i | input | H_W | Destination height |
| busy_o | output | 1 | Computation in progress |
| valid_o | output | 1 | Results updated this cycle |
| err_o | output | 1 | Last start had zero destination |
| master_o | output | Q_W | Master step value |
| div_ctrl_o | output | CTRL_W | Divider codes, luma [1:0], chroma [9:8] |
| y_step_a_o | output | Q_W | Luma step, master >> 2 |
| y_step_b_o | output | Q_W | Luma step a + offset |
| y_step_c_o | output | Q_W | Luma copy of master |
| c_step_a_o | output | Q_W | Chroma step, range-dependent shift |
| c_step_b_o | output | Q_W | Chroma step a + offset |
| c_step_c_o | output | Q_W | Chroma step, master >> 1 or master |
| c_step_d_o | output | Q_W | Copy of chroma step c |

## Verification
Every result is due at one fixed point. It arrives on the single edge that raises `valid_o`, which is H_W+22 edges after the accepting edge; with the bench's 6-bit heights that is 28 edges. The bench counts falling edges from acceptance. At each count before that point, it checks that `busy_o` is high and `valid_o` is low. At exactly that count it checks every output against arithmetic computed in the bench. One edge later it checks that the pulse has ended and that the outputs hold. For a rejected start, the check comes one edge after the attempt, and a stretch of idle cycles follows to confirm that nothing changed.

// File: rtl/vsp_pkg.sv
package vsp_pkg;
  // encoding doubles as the divider field code
  typedef enum logic [1:0] {
    MODE_ENL  = 2'b00,
    MODE_HALF = 2'b01,
    MODE_QTR  = 2'b10
  } vsp_mode_e;

  function automatic logic [1:0] pre_shift(input vsp_mode_e m);
    case (m)
      MODE_HALF: pre_shift = 2'd1;
      MODE_QTR:  pre_shift = 2'd2;
      default:   pre_shift = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/vsp_mode_sel.sv
module vsp_mode_sel
  import vsp_pkg::*;
#(
  parameter int H_W     = 16,
  parameter int FRAC_SH = 21,
  localparam int DVD_W  = H_W + FRAC_SH
) (
  input  logic [H_W-1:0]   src_h_i,
  input  logic [H_W-1:0]   dst_h_i,
  output vsp_mode_e        mode_o,
  output logic [DVD_W-1:0] dividend_o
);
  logic [H_W:0]   dst_x2;
  logic [H_W-1:0] src_pre;

  assign dst_x2 = {dst_h_i, 1'b0};

  always_comb begin
    if (dst_h_i >= src_h_i)            mode_o = MODE_ENL;
    else if (dst_x2 >= {1'b0, src_h_i}) mode_o = MODE_HALF;
    else                               mode_o = MODE_QTR;
  end

  assign src_pre    = src_h_i >> pre_shift(mode_o);
  assign dividend_o = DVD_W'(src_pre) << FRAC_SH;
endmodule

// File: rtl/vsp_divider.sv
module vsp_divider #(
  parameter int DVD_W = 37,
  parameter int DSR_W = 16,
  localparam int CNT_W = $clog2(DVD_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DSR_W-1:0] divisor_i,
  output logic             done_o,
  output logic [DVD_W-1:0] quot_o
);
  logic             run_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DSR_W:0]   rem_q, trial, rem_n;
  logic [DVD_W-1:0] quo_q;
  logic [DSR_W-1:0] dsr_q;
  logic             ge;

  // restoring step: shift in next dividend bit, subtract if it fits
  assign trial = {rem_q[DSR_W-1:0], quo_q[DVD_W-1]};
  assign ge    = trial >= {1'b0, dsr_q};
  assign rem_n = ge ? trial - {1'b0, dsr_q} : trial;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        rem_q <= '0;
        quo_q <= dividend_i;
        dsr_q <= divisor_i;
      end else if (run_q) begin
        rem_q <= rem_n;
        quo_q <= {quo_q[DVD_W-2:0], ge};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(DVD_W - 1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;
endmodule

// File: rtl/vsp_derive.sv
module vsp_derive
  import vsp_pkg::*;
#(
  parameter int             Q_W      = 32,
  parameter logic [Q_W-1:0] STEP_OFF = 'h514
) (
  input  logic [Q_W-1:0] master_i,
  input  vsp_mode_e      mode_i,
  output logic [Q_W-1:0] y_a_o,
  output logic [Q_W-1:0] y_b_o,
  output logic [Q_W-1:0] y_c_o,
  output logic [Q_W-1:0] c_a_o,
  output logic [Q_W-1:0] c_b_o,
  output logic [Q_W-1:0] c_c_o,
  output logic [Q_W-1:0] c_d_o
);
  logic enl;
  assign enl = (mode_i == MODE_ENL);

  assign y_a_o = master_i >> 2;
  assign y_b_o = y_a_o + STEP_OFF;
  assign y_c_o = master_i;
  assign c_a_o = enl ? (master_i >> 2) : (master_i >> 3);
  assign c_b_o = c_a_o + STEP_OFF;
  assign c_c_o = enl ? (master_i >> 1) : master_i;
  assign c_d_o = c_c_o;
endmodule

// File: rtl/vscale_param_gen.sv
module vscale_param_gen
  import vsp_pkg::*;
#(
  parameter int             H_W      = 16,
  parameter int             FRAC_SH  = 21,
  parameter int             Q_W      = 32,
  parameter int             CTRL_W   = 16,
  parameter logic [Q_W-1:0] STEP_OFF = 'h514,
  localparam int            DVD_W    = H_W + FRAC_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [H_W-1:0]    src_h_i,
  input  logic [H_W-1:0]    dst_h_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic              err_o,
  output logic [Q_W-1:0]    master_o,
  output logic [CTRL_W-1:0] div_ctrl_o,
  output logic [Q_W-1:0]    y_step_a_o,
  output logic [Q_W-1:0]    y_step_b_o,
  output logic [Q_W-1:0]    y_step_c_o,
  output logic [Q_W-1:0]    c_step_a_o,
  output logic [Q_W-1:0]    c_step_b_o,
  output logic [Q_W-1:0]    c_step_c_o,
  output logic [Q_W-1:0]    c_step_d_o
);
  vsp_mode_e        mode_c, mode_q;
  logic [DVD_W-1:0] dividend, quot;
  logic             acc, zero_hit, done;
  logic             busy_q, valid_q, err_q;
  logic [Q_W-1:0]   master_c;
  logic [Q_W-1:0]   y_a, y_b, y_c, c_a, c_b, c_c, c_d;

  vsp_mode_sel #(.H_W(H_W), .FRAC_SH(FRAC_SH)) i_mode_sel (
    .src_h_i   (src_h_i),
    .dst_h_i   (dst_h_i),
    .mode_o    (mode_c),
    .dividend_o(dividend)
  );

  assign acc      = start_i && !busy_q && (dst_h_i != '0);
  assign zero_hit = start_i && !busy_q && (dst_h_i == '0);

  vsp_divider #(.DVD_W(DVD_W), .DSR_W(H_W)) i_divider (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (acc),
    .dividend_i(dividend),
    .divisor_i (dst_h_i),
    .done_o    (done),
    .quot_o    (quot)
  );

  assign master_c = Q_W'(quot);

  vsp_derive #(.Q_W(Q_W), .STEP_OFF(STEP_OFF)) i_derive (
    .master_i(master_c),
    .mode_i  (mode_q),
    .y_a_o   (y_a),
    .y_b_o   (y_b),
    .y_c_o   (y_c),
    .c_a_o   (c_a),
    .c_b_o   (c_b),
    .c_c_o   (c_c),
    .c_d_o   (c_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_ENL;
      busy_q     <= 1'b0;
      valid_q    <= 1'b0;
      err_q      <= 1'b0;
      master_o   <= '0;
      div_ctrl_o <= '0;
      y_step_a_o <= '0;
      y_step_b_o <= '0;
      y_step_c_o <= '0;
      c_step_a_o <= '0;
      c_step_b_o <= '0;
      c_step_c_o <= '0;
      c_step_d_o <= '0;
    end else begin
      valid_q <= done;
      if (acc) begin
        mode_q <= mode_c;
        busy_q <= 1'b1;
        err_q  <= 1'b0;
      end else if (zero_hit) begin
        err_q <= 1'b1;
      end
      if (done) begin
        busy_q     <= 1'b0;
        master_o   <= master_c;
        div_ctrl_o <= '0;
        div_ctrl_o[1:0] <= mode_q;
        div_ctrl_o[9:8] <= mode_q;
        y_step_a_o <= y_a;
        y_step_b_o <= y_b;
        y_step_c_o <= y_c;
        c_step_a_o <= c_a;
        c_step_b_o <= c_b;
        c_step_c_o <= c_c;
        c_step_d_o <= c_d;
      end
    end
  end

  assign busy_o  = busy_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
endmodule

// File: rtl/vsp_chk.sv
module vsp_chk #(
  parameter int Q_W    = 32,
  parameter int CTRL_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              valid_o,
  input logic              err_o,
  input logic [Q_W-1:0]    master_o,
  input logic [CTRL_W-1:0] div_ctrl_o,
  input logic [Q_W-1:0]    y_step_a_o,
  input logic [Q_W-1:0]    y_step_c_o,
  input logic [Q_W-1:0]    c_step_c_o,
  input logic [Q_W-1:0]    c_step_d_o
);
  // R8
  busy_valid_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o);
  // R8
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R7
  master_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(master_o));
  // R1
  ctrl_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_ctrl_o[1:0] != 2'b11 && div_ctrl_o[9:8] == div_ctrl_o[1:0]);
  // R5
  luma_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_step_a_o == (y_step_c_o >> 2));
  // R6
  chroma_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_step_d_o == c_step_c_o);
  // R10
  err_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !busy_o && !valid_o);
endmodule

bind vscale_param_gen vsp_chk #(.Q_W(Q_W), .CTRL_W(CTRL_W)) i_vsp_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .valid_o   (valid_o),
  .err_o     (err_o),
  .master_o  (master_o),
  .div_ctrl_o(div_ctrl_o),
  .y_step_a_o(y_step_a_o),
  .y_step_c_o(y_step_c_o),
  .c_step_c_o(c_step_c_o),
  .c_step_d_o(c_step_d_o)
);

// File: tb/test_vscale_param_gen.sv
module test_vscale_param_gen;
  localparam int H_W = 6;
  localparam int LAT = H_W + 21 + 1;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [H_W-1:0] src_h_i = '0, dst_h_i = '0;
  logic busy_o, valid_o, err_o;
  logic [31:0] master_o, y_step_a_o, y_step_b_o, y_step_c_o;
  logic [31:0] c_step_a_o, c_step_b_o, c_step_c_o, c_step_d_o;
  logic [15:0] div_ctrl_o;

  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  vscale_param_gen #(.H_W(H_W)) i_vscale_param_gen (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .src_h_i(src_h_i), .dst_h_i(dst_h_i),
    .busy_o(busy_o), .valid_o(valid_o), .err_o(err_o),
    .master_o(master_o), .div_ctrl_o(div_ctrl_o),
    .y_step_a_o(y_step_a_o), .y_step_b_o(y_step_b_o), .y_step_c_o(y_step_c_o),
    .c_step_a_o(c_step_a_o), .c_step_b_o(c_step_b_o),
    .c_step_c_o(c_step_c_o), .c_step_d_o(c_step_d_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  task automatic check_outputs(input int src, input int dst);
    int k;
    logic enl;
    logic [31:0] m, ya, ca, cc;
    logic [15:0] ctrl;
    enl = dst >= src;
    k = enl ? 0 : ((2 * dst >= src) ? 1 : 2);
    m = 32'((64'(src >> k) << 21) / 64'(dst));
    ctrl = 16'(k) | (16'(k) << 8);
    ya = m >> 2;
    ca = enl ? (m >> 2) : (m >> 3);
    cc = enl ? (m >> 1) : m;
    case (k)
      0: chk("R2 master enlarge", master_o, m);
      1: chk("R3 master half", master_o, m);
      default: chk("R4 master quarter", master_o, m);
    endcase
    chk("R1 div ctrl", div_ctrl_o, ctrl);
    chk("R5 y_a", y_step_a_o, ya);
    chk("R5 y_b", y_step_b_o, ya + 32'h514);
    chk("R5 y_c", y_step_c_o, m);
    chk("R6 c_a", c_step_a_o, ca);
    chk("R6 c_b", c_step_b_o, ca + 32'h514);
    chk("R6 c_c", c_step_c_o, cc);
    chk("R6 c_d", c_step_d_o, cc);
  endtask

  // noise: pulse a different start mid-run (R9)
  task automatic run(input int src, input int dst, input bit noise);
    int n;
    logic [31:0] held;
    @(negedge clk);
    src_h_i = H_W'(src); dst_h_i = H_W'(dst); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 busy after accept", busy_o, 1'b1);
    chk("R10 err cleared on accept", err_o, 1'b0);
    n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (noise && n == 3) begin
        src_h_i = H_W'(src + 7); dst_h_i = H_W'(dst / 2 + 1); start_i = 1'b1;
      end else if (noise && n == 4) begin
        start_i = 1'b0;
      end
      if (valid_o || n > LAT + 4) break;
      if (busy_o !== 1'b1) chk("R8 busy during run", busy_o, 1'b1);
    end
    chk("R7 valid latency", 64'(n), 64'(LAT));
    chk("R8 busy low with valid", busy_o, 1'b0);
    check_outputs(src, dst);
    held = master_o;
    @(negedge clk);
    chk("R7 valid one cycle", valid_o, 1'b0);
    chk("R7 outputs hold", master_o, held);
  endtask

  initial begin
    #200000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy_o, 1'b0);
    chk("R11 valid", valid_o, 1'b0);
    chk("R11 err", err_o, 1'b0);
    chk("R11 master", master_o, 0);
    chk("R11 ctrl", div_ctrl_o, 0);
    chk("R11 c_b", c_step_b_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // directed range boundaries (R1)
    run(40, 40, 1'b0);
    run(40, 20, 1'b0);
    run(41, 20, 1'b0);
    run(40, 19, 1'b0);
    run(63, 1, 1'b0);
    run(1, 63, 1'b0);

    // R9 start while busy ignored
    run(50, 30, 1'b1);
    run(20, 33, 1'b1);

    // R10 zero destination
    held = master_o;
    @(negedge clk);
    src_h_i = 6'd12; dst_h_i = 6'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R10 err set", err_o, 1'b1);
    chk("R10 no busy", busy_o, 1'b0);
    for (int i = 0; i < LAT + 4; i++) begin
      @(negedge clk);
      if (valid_o !== 1'b0) chk("R10 no valid", valid_o, 1'b0);
    end
    chk("R10 master unchanged", master_o, held);
    chk("R10 err sticky", err_o, 1'b1);
    run(12, 9, 1'b0);
    chk("R10 err cleared", err_o, 1'b0);

    // near-exhaustive sweep R1..R8
    for (int s = 1; s < 64; s++)
      for (int d = 1; d < 64; d += 2)
        run(s, d, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule